// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Unit

This unit executes a single halfword or signed-byte transfer instruction for a 32-bit processor core. The caller pulses a start strobe together with the instruction word, the read data of the three registers named by the instruction, and the pipelined program-counter value. The unit then does three things in order:

- It forms a 32-bit effective address from a base register and an offset. The offset is either an 8-bit immediate or a register, and it is added or subtracted with wraparound. The address is taken before or after that adjustment.
- It performs one access over a request/acknowledge memory port.
- It finishes with a single-cycle completion pulse. During that pulse it offers up to two register write-backs.

Load data is shaped before it is written back. Loads can be unsigned halfword, sign-extended byte or sign-extended halfword. An unsigned halfword load from an odd address is rotated. A signed halfword load from an odd address is reduced to a sign-extended byte read. When the base and destination are the same register, the two write ports are ordered so that the loaded value is what remains. Encodings outside the supported set are flagged and cause no side effect.

Top module: `hsx_ldst_unit`

## Requirements
- R1: The immediate flag is instr[22]. When it is set, the offset is {instr[11:8], instr[3:0]} zero-extended; when it is clear, the offset is rm_data_i. The up flag is instr[23]: set means base+offset, clear means base−offset, both modulo 2^32. The pre-index flag is instr[24]: set means the bus address is the adjusted base, clear means the unadjusted base. The base index is instr[19:16], the destination index is instr[15:12] and the load flag is instr[20].
- R2: The adjusted base is written back through write port 0, with the index set to the base register, in two cases: when instr[24]=0, or when instr[24]=1 and the write-back flag instr[21]=1. With instr[24]=1 and instr[21]=0, write port 0 stays disabled.
- R3: When the base index is 15, the base is pc_i+4 for stores and pc_i for loads.
- R4: Sub-operation instr[6:5]=01 with instr[20]=1 reads a halfword. The size code is 01 (half) and the halfword is taken from mem_rdata_i[15:0]. It is zero-extended, then rotated right by 8 bits when address bit 0 is 1.
- R5: Sub-operation 10 with instr[20]=1 reads a byte. The size code is 00 (byte) and the byte is taken from mem_rdata_i[7:0] and sign-extended to 32 bits.
- R6: Sub-operation 11 with instr[20]=1 depends on address bit 0. At an even address it reads a halfword with size 01 and sign-extends 16 bits. At an odd address it reads a byte with size 00 and sign-extends 8 bits.
- R7: Sub-operation 01 with instr[20]=0 is a store. It drives mem_we_o=1, size 01, and mem_wdata_o equal to rd_data_i[15:0] zero-extended. It does not enable write port 1.
- R8: A load always enables write port 1 with the destination index and the shaped data. The consumer applies port 0 before port 1, so when the base and destination coincide, the register ends up holding the loaded value.
- R9: While mem_req_o is high and mem_ack_i is low, the request, address, size and write enable stay unchanged. A start pulse that arrives while an instruction is in progress is ignored.
- R10: done_o is high for exactly one cycle per accepted instruction. The write-port enables are only ever high in that cycle.
- R11: Sub-operation 00, or a store (instr[20]=0) with a sub-operation other than 01, is illegal. The unit issues no memory request, enables no write port, and raises illegal_o together with done_o.
- R12: After reset, mem_req_o, done_o, illegal_o and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| instr_i | input | 32 | Instruction word |
| rn_data_i | input | 32 | Base register read data |
| rm_data_i | input | 32 | Offset register read data |
| rd_data_i | input | 32 | Data register read data (store source) |
| pc_i | input | 32 | Pipelined program-counter value |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write enable |
| mem_size_o | output | 2 | Access size: 00 byte, 01 halfword |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal encoding, valid with done_o |
| wb0_en_o | output | 1 | Write port 0 (base) enable |
| wb0_idx_o | output | 4 | Write port 0 register index |
| wb0_data_o | output | 32 | Write port 0 data |
| wb1_en_o | output | 1 | Write port 1 (destination) enable |
| wb1_idx_o | output | 4 | Write port 1 register index |
| wb1_data_o | output | 32 | Write port 1 data |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- Odd-address halfword loads. A design that omits the rotation returns 0x0000ABCD where 0xCD0000AB is expected.
- Odd-address signed halfword loads. A design without the byte fallback asks for a halfword and sign-extends the wrong bit.
- A base address that wraps through zero. This exposes truncated arithmetic.
- Program-counter-based loads and stores. If the store adjustment is applied to both kinds, the load address comes out 4 bytes too high.
- A load whose base and destination are the same register. If the write ports are swapped, the register is left holding the adjusted base instead of the loaded byte.
- Illegal encodings. These must produce no request and no write.
- A stray start pulse during a stalled access. This must not restart the unit or alter the held request.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_WB     = 2'd2
    } hsx_state_e;

    // Access size codes on the memory port
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    // Sub-operation codes (instruction bits 6:5)
    localparam logic [1:0] SOP_SWAP  = 2'b00;
    localparam logic [1:0] SOP_UHALF = 2'b01;
    localparam logic [1:0] SOP_SBYTE = 2'b10;
    localparam logic [1:0] SOP_SHALF = 2'b11;

    // Instruction field positions
    localparam int BIT_PRE   = 24;
    localparam int BIT_UP    = 23;
    localparam int BIT_IMM   = 22;
    localparam int BIT_WBK   = 21;
    localparam int BIT_LOAD  = 20;
    localparam int RN_LSB    = 16;
    localparam int RD_LSB    = 12;
    localparam int IMMH_LSB  = 8;
    localparam int SOP_LSB   = 5;
    localparam int RM_LSB    = 0;

endpackage

// File: rtl/hsx_agen.sv
// Decode and effective-address generation, purely combinational.
module hsx_agen
    import hsx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIW    = 4,
    parameter int PC_IDX = 15,
    parameter int PC_ADJ = 4
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rn_data,
    input  logic [XLEN-1:0] rm_data,
    input  logic [XLEN-1:0] pc,
    output logic            is_load,
    output logic [1:0]      sop,
    output logic            illegal,
    output logic            wb_base,
    output logic [RIW-1:0]  base_idx,
    output logic [RIW-1:0]  dst_idx,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] new_base,
    output logic [1:0]      size
);
    localparam int              IMM_W   = 8;
    localparam int              NIB_W   = IMM_W / 2;
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(PC_ADJ);
    localparam logic [RIW-1:0]  PC_SEL  = RIW'(PC_IDX);

    logic            pre, up, use_imm, wbk;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] base;

    always_comb begin
        pre      = instr[BIT_PRE];
        up       = instr[BIT_UP];
        use_imm  = instr[BIT_IMM];
        wbk      = instr[BIT_WBK];
        is_load  = instr[BIT_LOAD];
        sop      = instr[SOP_LSB +: 2];
        base_idx = instr[RN_LSB +: RIW];
        dst_idx  = instr[RD_LSB +: RIW];

        if (use_imm)
            offset = {{(XLEN-IMM_W){1'b0}}, instr[IMMH_LSB +: NIB_W], instr[RM_LSB +: NIB_W]};
        else
            offset = rm_data;

        if (base_idx == PC_SEL)
            base = is_load ? pc : (pc + PC_STEP);
        else
            base = rn_data;

        new_base = up ? (base + offset) : (base - offset);
        addr     = pre ? new_base : base;
        wb_base  = !pre || wbk;

        illegal  = (sop == SOP_SWAP) || (!is_load && (sop != SOP_UHALF));

        if (sop == SOP_SBYTE)
            size = SZ_BYTE;
        else if ((sop == SOP_SHALF) && addr[0])
            size = SZ_BYTE;
        else
            size = SZ_HALF;
    end

endmodule

// File: rtl/hsx_ldfmt.sv
// Shapes raw read data into the 32-bit register value.
module hsx_ldfmt
    import hsx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      sop,
    input  logic            addr_lsb,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] result
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [BYTE_W-1:0] b;
    logic [HALF_W-1:0] h;
    logic [XLEN-1:0]   h_zext, h_rot, b_sext, h_sext;

    always_comb begin
        b      = rdata[BYTE_W-1:0];
        h      = rdata[HALF_W-1:0];
        h_zext = {{(XLEN-HALF_W){1'b0}}, h};
        h_rot  = addr_lsb ? {h_zext[BYTE_W-1:0], h_zext[XLEN-1:BYTE_W]} : h_zext;
        b_sext = {{(XLEN-BYTE_W){b[BYTE_W-1]}}, b};
        h_sext = {{(XLEN-HALF_W){h[HALF_W-1]}}, h};

        case (sop)
            SOP_UHALF: result = h_rot;
            SOP_SBYTE: result = b_sext;
            SOP_SHALF: result = addr_lsb ? b_sext : h_sext;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/hsx_ldst_unit.sv
module hsx_ldst_unit
    import hsx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIW    = 4,
    parameter int PC_IDX = 15,
    parameter int PC_ADJ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rn_data_i,
    input  logic [XLEN-1:0] rm_data_i,
    input  logic [XLEN-1:0] rd_data_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [1:0]      mem_size_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_ack_i,
    output logic            done_o,
    output logic            illegal_o,
    output logic            wb0_en_o,
    output logic [RIW-1:0]  wb0_idx_o,
    output logic [XLEN-1:0] wb0_data_o,
    output logic            wb1_en_o,
    output logic [RIW-1:0]  wb1_idx_o,
    output logic [XLEN-1:0] wb1_data_o
);
    localparam int STORE_W = 16;

    typedef struct packed {
        hsx_state_e      st;
        logic            load;
        logic [1:0]      sop;
        logic            ill;
        logic            wb_base;
        logic [RIW-1:0]  bidx;
        logic [RIW-1:0]  didx;
        logic [XLEN-1:0] addr;
        logic [1:0]      size;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] nbase;
        logic [XLEN-1:0] res;
    } ctx_t;

    ctx_t r_d, r_q;

    // Address generation from live inputs (used only at start)
    logic            ag_load, ag_ill, ag_wb;
    logic [1:0]      ag_sop, ag_size;
    logic [RIW-1:0]  ag_bidx, ag_didx;
    logic [XLEN-1:0] ag_addr, ag_nbase;

    hsx_agen #(
        .XLEN   (XLEN),
        .RIW    (RIW),
        .PC_IDX (PC_IDX),
        .PC_ADJ (PC_ADJ)
    ) u_agen (
        .instr    (instr_i),
        .rn_data  (rn_data_i),
        .rm_data  (rm_data_i),
        .pc       (pc_i),
        .is_load  (ag_load),
        .sop      (ag_sop),
        .illegal  (ag_ill),
        .wb_base  (ag_wb),
        .base_idx (ag_bidx),
        .dst_idx  (ag_didx),
        .addr     (ag_addr),
        .new_base (ag_nbase),
        .size     (ag_size)
    );

    // Load data shaping from the registered access
    logic [XLEN-1:0] fmt_res;

    hsx_ldfmt #(
        .XLEN (XLEN)
    ) u_ldfmt (
        .sop      (r_q.sop),
        .addr_lsb (r_q.addr[0]),
        .rdata    (mem_rdata_i),
        .result   (fmt_res)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.load    = ag_load;
                    r_d.sop     = ag_sop;
                    r_d.ill     = ag_ill;
                    r_d.wb_base = ag_wb;
                    r_d.bidx    = ag_bidx;
                    r_d.didx    = ag_didx;
                    r_d.addr    = ag_addr;
                    r_d.size    = ag_size;
                    r_d.wdata   = {{(XLEN-STORE_W){1'b0}}, rd_data_i[STORE_W-1:0]};
                    r_d.nbase   = ag_nbase;
                    r_d.res     = '0;
                    r_d.st      = ag_ill ? ST_WB : ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (mem_ack_i) begin
                    r_d.res = fmt_res;
                    r_d.st  = ST_WB;
                end
            end
            ST_WB:   r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req_o   = (r_q.st == ST_ACCESS);
        mem_we_o    = mem_req_o && !r_q.load;
        mem_size_o  = r_q.size;
        mem_addr_o  = r_q.addr;
        mem_wdata_o = r_q.wdata;
        done_o      = (r_q.st == ST_WB);
        illegal_o   = done_o && r_q.ill;
        wb0_en_o    = done_o && !r_q.ill && r_q.wb_base;
        wb0_idx_o   = r_q.bidx;
        wb0_data_o  = r_q.nbase;
        wb1_en_o    = done_o && !r_q.ill && r_q.load;
        wb1_idx_o   = r_q.didx;
        wb1_data_o  = r_q.res;
    end

    // ---------------- assertions ----------------
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_size_o))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en_o || wb1_en_o) |-> done_o); // R10

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb0_en_o && !wb1_en_o && !$past(mem_req_o))); // R11

    AST_STORE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_size_o == SZ_HALF)); // R7

    AST_DEST_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_en_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o)); // R8

endmodule

// File: tb/hsx_ldst_unit_tb.sv
`timescale 1ns/1ps
module hsx_ldst_unit_tb;

    localparam real PERIOD = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0, rn_data_i = '0, rm_data_i = '0, rd_data_i = '0, pc_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [1:0]  mem_size_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        done_o, illegal_o;
    logic        wb0_en_o, wb1_en_o;
    logic [3:0]  wb0_idx_o, wb1_idx_o;
    logic [31:0] wb0_data_o, wb1_data_o;

    always #(PERIOD/2) clk = ~clk;

    hsx_ldst_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .rn_data_i(rn_data_i), .rm_data_i(rm_data_i), .rd_data_i(rd_data_i), .pc_i(pc_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ack_i(mem_ack_i), .done_o(done_o), .illegal_o(illegal_o),
        .wb0_en_o(wb0_en_o), .wb0_idx_o(wb0_idx_o), .wb0_data_o(wb0_data_o),
        .wb1_en_o(wb1_en_o), .wb1_idx_o(wb1_idx_o), .wb1_data_o(wb1_data_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [31:0] regs [16];

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rn;
        logic [31:0] rm;
        logic [31:0] rd;
        logic [31:0] pc;
        logic [31:0] mem;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        we;
        logic [31:0] wdata;
        logic        ill;
        logic        w0en;
        logic [3:0]  w0idx;
        logic [31:0] w0dat;
        logic        w1en;
        logic [3:0]  w1idx;
        logic [31:0] w1dat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R1 R4: pre, up, imm 0x12, even halfword
        '{32'hE1D231B2, 32'h1000, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hDEAD8001, 32'h1012, 2'b01, 1'b0, 32'h0,
          1'b0, 1'b0, 4'd2, 32'h0, 1'b1, 4'd3, 32'h00008001, 8'd4},
        // R2 R4: post, down, register offset, odd halfword rotated
        '{32'hE01450B6, 32'h2001, 32'h10, 32'h0, 32'h0, 32'h1234ABCD, 32'h2001, 2'b01, 1'b0, 32'h0,
          1'b0, 1'b1, 4'd4, 32'h1FF1, 1'b1, 4'd5, 32'hCD0000AB, 8'd4},
        // R1 R5: pre, up, write-back, wraps through zero
        '{32'hE1B170D8, 32'hFFFFFFF0, 32'h20, 32'h0, 32'h0, 32'hFFFFFF80, 32'h10, 2'b00, 1'b0, 32'h0,
          1'b0, 1'b1, 4'd1, 32'h10, 1'b1, 4'd7, 32'hFFFFFF80, 8'd5},
        // R6: signed half, even address, pre down
        '{32'hE159A0F4, 32'h3000, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00008000, 32'h2FFC, 2'b01, 1'b0, 32'h0,
          1'b0, 1'b0, 4'd9, 32'h0, 1'b1, 4'd10, 32'hFFFF8000, 8'd6},
        // R6: signed half, odd address falls back to byte
        '{32'hE159A0F3, 32'h3000, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h123456F0, 32'h2FFD, 2'b00, 1'b0, 32'h0,
          1'b0, 1'b0, 4'd9, 32'h0, 1'b1, 4'd10, 32'hFFFFFFF0, 8'd6},
        // R7 R2: store, pre up imm 0x20 with write-back
        '{32'hE1EBC2B0, 32'h4000, 32'hFFFFFFFF, 32'hCAFEBEEF, 32'h0, 32'h0, 32'h4020, 2'b01, 1'b1, 32'h0000BEEF,
          1'b0, 1'b1, 4'd11, 32'h4020, 1'b0, 4'd12, 32'h0, 8'd7},
        // R3: store with program-counter base gets +4
        '{32'hE1CF20B8, 32'h0, 32'hFFFFFFFF, 32'h00001234, 32'h8008, 32'h0, 32'h8014, 2'b01, 1'b1, 32'h00001234,
          1'b0, 1'b0, 4'd15, 32'h0, 1'b0, 4'd2, 32'h0, 8'd3},
        // R3: load with program-counter base, no extra 4
        '{32'hE1DF30B8, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h8008, 32'h5555AAAA, 32'h8010, 2'b01, 1'b0, 32'h0,
          1'b0, 1'b0, 4'd15, 32'h0, 1'b1, 4'd3, 32'h0000AAAA, 8'd3},
        // R8: base equals destination, post index
        '{32'hE0D550D1, 32'h100, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hAAAAAA7F, 32'h100, 2'b00, 1'b0, 32'h0,
          1'b0, 1'b1, 4'd5, 32'h101, 1'b1, 4'd5, 32'h0000007F, 8'd8},
        // R11: swap space sub-operation 00
        '{32'hE1D23192, 32'h1000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 1'b0, 32'h0,
          1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 8'd11},
        // R11: store with signed-byte sub-operation
        '{32'hE1EBC2D0, 32'h4000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 1'b0, 32'h0,
          1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 8'd11}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.req);
        @(negedge clk);
        instr_i = v.instr; rn_data_i = v.rn; rm_data_i = v.rm; rd_data_i = v.rd; pc_i = v.pc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (v.ill) begin
            chk(done_o && illegal_o, rq, {30'b0, done_o, illegal_o}, 32'h3);
            chk(!mem_req_o && !wb0_en_o && !wb1_en_o, rq,
                {29'b0, mem_req_o, wb0_en_o, wb1_en_o}, 32'h0);
        end else begin
            chk(mem_req_o == 1'b1, rq, {31'b0, mem_req_o}, 32'h1);
            chk(mem_addr_o == v.addr, rq, mem_addr_o, v.addr);
            chk(mem_size_o == v.size, rq, {30'b0, mem_size_o}, {30'b0, v.size});
            chk(mem_we_o == v.we, rq, {31'b0, mem_we_o}, {31'b0, v.we});
            if (v.we) chk(mem_wdata_o == v.wdata, rq, mem_wdata_o, v.wdata);
            // R9: stall one cycle without ack and inject a stray start
            start_i = 1'b1;
            instr_i = 32'hE1D231B2; rn_data_i = 32'h7777;
            @(negedge clk);
            start_i = 1'b0;
            chk(mem_req_o && mem_addr_o == v.addr, "R9", mem_addr_o, v.addr);
            mem_rdata_i = v.mem;
            mem_ack_i = 1'b1;
            @(negedge clk);
            mem_ack_i = 1'b0;
            mem_rdata_i = 32'h5A5A5A5A;
            chk(done_o && !illegal_o, rq, {30'b0, done_o, illegal_o}, 32'h2);
            chk(wb0_en_o == v.w0en, rq, {31'b0, wb0_en_o}, {31'b0, v.w0en});
            if (v.w0en) begin
                chk(wb0_idx_o == v.w0idx, rq, {28'b0, wb0_idx_o}, {28'b0, v.w0idx});
                chk(wb0_data_o == v.w0dat, rq, wb0_data_o, v.w0dat);
            end
            chk(wb1_en_o == v.w1en, rq, {31'b0, wb1_en_o}, {31'b0, v.w1en});
            if (v.w1en) begin
                chk(wb1_idx_o == v.w1idx, rq, {28'b0, wb1_idx_o}, {28'b0, v.w1idx});
                chk(wb1_data_o == v.w1dat, rq, wb1_data_o, v.w1dat);
            end
            // consumer applies base port first, destination last (R8)
            if (wb0_en_o) regs[wb0_idx_o] = wb0_data_o;
            if (wb1_en_o) regs[wb1_idx_o] = wb1_data_o;
        end
        @(negedge clk);
        // R10: single-cycle done; R9: stray start left nothing pending
        chk(!done_o && !mem_req_o && !wb0_en_o && !wb1_en_o, "R10",
            {28'b0, done_o, mem_req_o, wb0_en_o, wb1_en_o}, 32'h0);
        @(negedge clk);
        chk(!mem_req_o && !done_o, "R9", {30'b0, mem_req_o, done_o}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!mem_req_o && !done_o && !illegal_o && !wb0_en_o && !wb1_en_o, "R12",
            {27'b0, mem_req_o, done_o, illegal_o, wb0_en_o, wb1_en_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !done_o, "R12", {30'b0, mem_req_o, done_o}, 32'h0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R8: after ordered write-back, register 5 holds the loaded byte
        chk(regs[5] == 32'h0000007F, "R8", regs[5], 32'h0000007F);
        // R2: base register 4 updated by post index
        chk(regs[4] == 32'h00001FF1, "R2", regs[4], 32'h00001FF1);

        // R12: reset in the middle of an access clears the request
        @(negedge clk);
        instr_i = VECS[0].instr; rn_data_i = VECS[0].rn; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o == 1'b1, "R12", {31'b0, mem_req_o}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req_o && !done_o, "R12", {30'b0, mem_req_o, done_o}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule